// File: doc/BRIEF.md
# External Bus Release Arbiter

This block decides, cycle by cycle, whether the external memory bus belongs to the local memory controller or to an outside bus master. An outside master asks for the bus on a request input. The arbiter answers on a registered acknowledge output, but only at a cycle boundary that is safe to hand over. The local controller marks every finished bus cycle with a one-cycle end strobe. When it is idle, it holds that strobe high. Three lock flags travel with the strobe and mark sub-cycles that must not be separated:

- the pieces of an access split across a narrow bus;
- the beats of a 32-byte line fill or write-back;
- the read and write halves of an atomic test-and-set or a dual-address DMA move.

A lock flag that is high when the strobe is sampled means that more sub-cycles of the same sequence follow.

A pending memory refresh takes the same safe boundaries. Refresh wins over a new bus request that arrives at the same boundary. While the bus is lent out, no refresh can run. Instead, the arbiter withdraws acknowledge and waits for the outside master to drop its request. It then takes the bus back and starts the refresh at once. The local-grant output tells the local controller when it may drive the bus. The refresh-start output is a one-cycle pulse to the refresh sequencer.

Top module: `ext_bus_arbiter`

## Requirements
- R1: After a synchronous active-low reset, acknowledge is low, local grant is high, refresh start is low and no refresh is remembered as pending.
- R2: With the request high, acknowledge rises, and local grant falls, only at the clock edge where the end strobe is high and all three lock flags are low. Without an end strobe, acknowledge stays low however long the request is held.
- R3: An end strobe sampled with the narrow-bus split lock high is not a handover point. Acknowledge stays low.
- R4: An end strobe sampled with the line-burst lock high is not a handover point. Acknowledge stays low.
- R5: An end strobe sampled with the atomic read-modify-write lock high is not a handover point. Acknowledge stays low.
- R6: When the request is low while acknowledge is high, acknowledge falls and local grant rises at the next edge. A request withdrawn before any handover point never produces acknowledge.
- R7: A refresh request pulse is remembered until a handover point. At that edge, refresh start goes high for exactly one cycle. End strobes sampled with any lock high do not start it.
- R8: Refresh start is never high while acknowledge is high, and never while the bus is being reclaimed.
- R9: If refresh is pending while the bus is released, acknowledge falls at the next edge and local grant stays low. Local grant returns, together with the refresh-start pulse, only at the edge after the outside master lowers its request.
- R10: When a refresh is pending and the request is high at the same handover point, the refresh starts and acknowledge stays low. The request is granted at the next handover point.
- R11: Acknowledge and local grant are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| extReq | input | 1 | Bus request from the outside master |
| refreshReq | input | 1 | Refresh request pulse |
| cycleEnd | input | 1 | Local bus cycle ended this clock (high when idle) |
| lockSplit | input | 1 | More sub-cycles of a width-split access follow |
| lockBurst | input | 1 | More beats of a 32-byte line transfer follow |
| lockRmw | input | 1 | Write half of an atomic or dual-address move follows |
| busAck | output | 1 | Registered acknowledge to the outside master |
| localGrant | output | 1 | Local controller owns the bus |
| refreshStart | output | 1 | One-cycle pulse that starts a refresh |

## Verification
The request is presented in several ways:

- with no end strobe at all;
- with strobes under each lock flag in turn, then with an unlocked strobe;
- withdrawn before any boundary.

Together these show that acknowledge depends on both the strobe and the locks, and that each lock alone blocks handover. Refresh pulses are tried alone under a burst lock, together with a request at one boundary, and during a release. This separates the deferral by locks, the priority of refresh over a grant, and the reclaim handshake in which acknowledge falls before the request does.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    ST_LOCAL     = 2'd0,
    ST_RELEASING = 2'd1,
    ST_RELEASED  = 2'd2,
    ST_RECLAIM   = 2'd3
  } arbState_e;

  typedef struct packed {
    logic setAck;
    logic clrAck;
    logic fireRefresh;
  } ctlStrobes_t;

endpackage

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        refreshReq,
  input  ctlStrobes_t strobes,
  output logic        refPendEff,
  output logic        busAck,
  output logic        refreshStart
);

  logic refPend;

  // a request arriving this cycle counts as pending at once
  assign refPendEff = refPend | refreshReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refPend      <= 1'b0;
      busAck       <= 1'b0;
      refreshStart <= 1'b0;
    end else begin
      refPend      <= refPendEff & ~strobes.fireRefresh;
      refreshStart <= strobes.fireRefresh;
      if (strobes.setAck)      busAck <= 1'b1;
      else if (strobes.clrAck) busAck <= 1'b0;
    end
  end

endmodule

// File: rtl/arb_control.sv
module arb_control
  import arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        extReq,
  input  logic        cycleEnd,
  input  logic        anyLock,
  input  logic        refPendEff,
  output ctlStrobes_t strobes,
  output logic        localGrant
);

  arbState_e state, stateNext;
  logic      boundary;

  assign boundary   = cycleEnd & ~anyLock;
  assign localGrant = (state == ST_LOCAL) || (state == ST_RELEASING);

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_LOCAL, ST_RELEASING: begin
        if (boundary && refPendEff) begin
          strobes.fireRefresh = 1'b1;
          stateNext = extReq ? ST_RELEASING : ST_LOCAL;
        end else if (boundary && extReq) begin
          strobes.setAck = 1'b1;
          stateNext = ST_RELEASED;
        end else begin
          stateNext = extReq ? ST_RELEASING : ST_LOCAL;
        end
      end
      ST_RELEASED: begin
        if (!extReq) begin
          strobes.clrAck      = 1'b1;
          strobes.fireRefresh = refPendEff;
          stateNext = ST_LOCAL;
        end else if (refPendEff) begin
          strobes.clrAck = 1'b1;
          stateNext = ST_RECLAIM;
        end
      end
      ST_RECLAIM: begin
        if (!extReq) begin
          strobes.fireRefresh = 1'b1;
          stateNext = ST_LOCAL;
        end
      end
      default: stateNext = ST_LOCAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_LOCAL;
    else       state <= stateNext;
  end

endmodule

// File: rtl/ext_bus_arbiter.sv
module ext_bus_arbiter
  import arb_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic extReq,
  input  logic refreshReq,
  input  logic cycleEnd,
  input  logic lockSplit,
  input  logic lockBurst,
  input  logic lockRmw,
  output logic busAck,
  output logic localGrant,
  output logic refreshStart
);

  ctlStrobes_t strobes;
  logic        refPendEff;
  logic        anyLock;

  assign anyLock = lockSplit | lockBurst | lockRmw;

  arb_control ctl_i (
    .clk        (clk),
    .rstN       (rstN),
    .extReq     (extReq),
    .cycleEnd   (cycleEnd),
    .anyLock    (anyLock),
    .refPendEff (refPendEff),
    .strobes    (strobes),
    .localGrant (localGrant)
  );

  arb_datapath dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .refreshReq   (refreshReq),
    .strobes      (strobes),
    .refPendEff   (refPendEff),
    .busAck       (busAck),
    .refreshStart (refreshStart)
  );

endmodule

// File: rtl/arb_checker.sv
module arb_checker (
  input logic clk,
  input logic rstN,
  input logic extReq,
  input logic cycleEnd,
  input logic lockSplit,
  input logic lockBurst,
  input logic lockRmw,
  input logic busAck,
  input logic localGrant,
  input logic refreshStart
);

  a_r2_ack_needs_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busAck) |-> ($past(cycleEnd) && $past(extReq)));

  a_r3_split_blocks: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busAck) |-> !$past(lockSplit));

  a_r4_burst_blocks: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busAck) |-> !$past(lockBurst));

  a_r5_rmw_blocks: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busAck) |-> !$past(lockRmw));

  a_r6_ack_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    (busAck && !extReq) |=> !busAck);

  a_r8_no_refresh_released: assert property (@(posedge clk) disable iff (!rstN)
    refreshStart |-> !busAck);

  a_r9_reclaim_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!busAck && !localGrant && extReq) |=> (!localGrant && !busAck));

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(busAck && localGrant));

endmodule

bind ext_bus_arbiter arb_checker chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .extReq       (extReq),
  .cycleEnd     (cycleEnd),
  .lockSplit    (lockSplit),
  .lockBurst    (lockBurst),
  .lockRmw      (lockRmw),
  .busAck       (busAck),
  .localGrant   (localGrant),
  .refreshStart (refreshStart)
);

// File: tb/ext_bus_arbiter_tb_top.sv
module ext_bus_arbiter_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extReq = 1'b0, refreshReq = 1'b0, cycleEnd = 1'b0;
  logic lockSplit = 1'b0, lockBurst = 1'b0, lockRmw = 1'b0;
  logic busAck, localGrant, refreshStart;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ext_bus_arbiter dut_i (
    .clk(clk), .rstN(rstN), .extReq(extReq), .refreshReq(refreshReq),
    .cycleEnd(cycleEnd), .lockSplit(lockSplit), .lockBurst(lockBurst),
    .lockRmw(lockRmw), .busAck(busAck), .localGrant(localGrant),
    .refreshStart(refreshStart)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect3(string req, logic ack, logic grant, logic rs);
    nChecks++;
    if (busAck !== ack || localGrant !== grant || refreshStart !== rs) begin
      nFails++;
      $display("FAIL %s: ack/grant/rs actual %b%b%b expected %b%b%b",
               req, busAck, localGrant, refreshStart, ack, grant, rs);
    end
  endtask

  task automatic idle();
    extReq = 0; refreshReq = 0; cycleEnd = 0;
    lockSplit = 0; lockBurst = 0; lockRmw = 0;
  endtask

  task automatic t_reset();
    expect3("R1 reset", 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_no_strobe();
    extReq = 1; cycleEnd = 0;
    for (int i = 0; i < 4; i++) begin
      step();
      expect3("R2 no strobe", 1'b0, 1'b1, 1'b0);
    end
    extReq = 0; step();
    cycleEnd = 1; step();
    expect3("R6 withdrawn early", 1'b0, 1'b1, 1'b0);
    idle(); step();
  endtask

  task automatic t_locks();
    extReq = 1; cycleEnd = 1;
    lockSplit = 1; step();
    expect3("R3 split lock", 1'b0, 1'b1, 1'b0);
    lockSplit = 0; lockBurst = 1; step();
    expect3("R4 burst lock", 1'b0, 1'b1, 1'b0);
    lockBurst = 0; lockRmw = 1; step();
    expect3("R5 rmw lock", 1'b0, 1'b1, 1'b0);
    lockRmw = 0; step();
    expect3("R2 grant at boundary", 1'b1, 1'b0, 1'b0);
    cycleEnd = 0; step();
    expect3("R11 released", 1'b1, 1'b0, 1'b0);
    extReq = 0; step();
    expect3("R6 release ends", 1'b0, 1'b1, 1'b0);
    idle(); step();
  endtask

  task automatic t_refresh();
    refreshReq = 1; step();
    refreshReq = 0;
    expect3("R7 pending no strobe", 1'b0, 1'b1, 1'b0);
    cycleEnd = 1; lockBurst = 1; step();
    expect3("R7 deferred by lock", 1'b0, 1'b1, 1'b0);
    lockBurst = 0; step();
    expect3("R7 refresh starts", 1'b0, 1'b1, 1'b1);
    cycleEnd = 0; step();
    expect3("R7 single pulse", 1'b0, 1'b1, 1'b0);
    idle(); step();
  endtask

  task automatic t_reclaim();
    extReq = 1; cycleEnd = 1; step();
    expect3("R2 grant", 1'b1, 1'b0, 1'b0);
    cycleEnd = 0; refreshReq = 1; step();
    refreshReq = 0;
    expect3("R9 ack dropped", 1'b0, 1'b0, 1'b0);
    cycleEnd = 1;
    for (int i = 0; i < 3; i++) begin
      step();
      expect3("R8 no refresh while reclaiming", 1'b0, 1'b0, 1'b0);
    end
    cycleEnd = 0; extReq = 0; step();
    expect3("R9 reclaimed with refresh", 1'b0, 1'b1, 1'b1);
    step();
    expect3("R9 after reclaim", 1'b0, 1'b1, 1'b0);
    idle(); step();
  endtask

  task automatic t_priority();
    extReq = 1; refreshReq = 1; cycleEnd = 1; step();
    refreshReq = 0;
    expect3("R10 refresh first", 1'b0, 1'b1, 1'b1);
    step();
    expect3("R10 grant next boundary", 1'b1, 1'b0, 1'b0);
    extReq = 0; cycleEnd = 0; step();
    expect3("R6 drop after priority", 1'b0, 1'b1, 1'b0);
    idle(); step();
  endtask

  initial begin
    idle();
    step(); step();
    rstN = 1'b1;
    step();
    t_reset();
    t_no_strobe();
    t_locks();
    t_refresh();
    t_reclaim();
    t_priority();
    finished = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule